// File: doc/BRIEF.md
# Time-Shared I/Q Interpolating FIR Filter

This block shapes two spread chip streams, one for the in-phase and one for the quadrature channel. It raises their sample rate by four with a lowpass FIR. Each accepted chip is a single bit per channel that stands for +1 or -1. A blank flag can replace both chips with a zero sample. Internally the chip is followed by three zero samples, and the stuffed stream passes through a 12-tap filter. Both channels use the same coefficients, so a single datapath serves both of them. That datapath runs eight output slots per input chip, alternating between I and Q within each of the four interpolation phases.

No multiplier is needed. A zero sample reads its coefficient from the upper half of a coefficient RAM, and that half always holds zero. A negative chip subtracts the coefficient instead of adding it. The twelve taps are split into two banks of six. Each bank has its own 16-word RAM and its own accumulator that sums one term per cycle. A pipeline register holds each partial sum, and a final adder combines the two into a sample wide enough that it cannot overflow.

Coefficients are loaded in program mode through a tap-index write port. Raising program mode while a chip is being processed freezes the filter until the mode is lowered again.

Top module: `fir_iq_interp`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` is 0 and `ready` is 1 while `prog_mode` is 0. All coefficients and all delay-line samples are zero.
- R2: Each accepted chip yields exactly eight single-cycle `out_valid` pulses, ordered phase 0 I, phase 0 Q, phase 1 I, and so on up to phase 3 Q. `out_q` is 0 for I and 1 for Q. The first pulse appears on the 9th rising edge after the edge that accepted the chip, and each later pulse follows 8 edges after the one before it.
- R3: For phase p (0..3) of chip n, each channel outputs `h[p]*c[n] + h[p+4]*c[n-1] + h[p+8]*c[n-2]`. Here h[k] is the signed 12-bit coefficient of tap k, c is +1 for chip bit 1, -1 for chip bit 0 and 0 for a blank chip, and chips before reset count as 0.
- R4: A chip accepted with `chip_blank`=1 contributes zero on both channels, whatever the coefficient values.
- R5: A write with `prog_mode`=1, `prog_we`=1 and no chip in progress stores `prog_coef` as the coefficient of tap `prog_tap` (0..11). Tap indices 12..15 are ignored.
- R6: A write is ignored when `prog_mode` is 0, and also when a chip is still in progress.
- R7: While `prog_mode` is 1, the filter holds its state and `out_valid` stays 0. Once `prog_mode` returns to 0, the remaining outputs of the interrupted chip follow with unchanged values.
- R8: `ready` is 1 only when no chip is in progress and `prog_mode` is 0. A `chip_stb` while `ready` is 0 has no effect.
- R9: `out_data` holds every sum without wrapping. With all twelve coefficients at -2048, outputs reach exactly -6144 and +6144, and no output ever exceeds 12*2048 in magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal datapath clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_mode | input | 1 | Program mode; pauses filtering |
| prog_we | input | 1 | Coefficient write strobe |
| prog_tap | input | 4 | Tap index to write |
| prog_coef | input | 12 | Signed coefficient value |
| chip_stb | input | 1 | Offers a new chip pair |
| chip_i | input | 1 | I chip bit (1 means +1) |
| chip_q | input | 1 | Q chip bit (1 means +1) |
| chip_blank | input | 1 | Replace both chips by zero |
| ready | output | 1 | A chip may be accepted this cycle |
| out_valid | output | 1 | Output sample strobe |
| out_q | output | 1 | 0: I sample, 1: Q sample |
| out_data | output | 16 | Signed output sample |

## Verification
The hardest condition to reach from the ports is a pause that lands in the middle of an output slot. At that point coefficient reads, delayed signs and a pending partial sum are all in flight. The bench offers a chip and raises program mode twenty cycles later, so the pause falls inside the third slot. It tries a coefficient write during the pause, lowers the mode again, and requires every remaining sample to match the model built from the unchanged coefficients. Random chip, blank and coefficient patterns are mixed with directed extremes, and each output is compared against a polyphase model in the bench that draws on the last three chips of each channel.

// File: rtl/fir_iq_pkg.sv
package fir_iq_pkg;
  // One delay-line sample: zero marks a stuffed or blank slot, neg a -1 chip
  typedef struct packed {
    logic zero;
    logic neg;
  } samp_t;
endpackage

// File: rtl/fir_coef_ram.sv
module fir_coef_ram #(
  parameter int CW  = 12,
  parameter int RAW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic                 re,
  input  logic [RAW-1:0]       addr,
  input  logic signed [CW-1:0] wdata,
  output logic signed [CW-1:0] rdata
);
  localparam int DEPTH = 1 << RAW;

  logic signed [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[addr] <= wdata;
      if (re) rdata <= mem[addr];
    end
  end

  // Upper half is never written, so a read there returns zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr[RAW-1]) |=> (rdata == '0));
endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line
  import fir_iq_pkg::*;
#(
  parameter int NTAP = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  samp_t                  din,
  output samp_t [NTAP-1:0]       taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP; k++) taps[k] <= '{zero: 1'b1, neg: 1'b0};
    end else if (shift_en) begin
      taps[0] <= din;
      for (int k = 1; k < NTAP; k++) taps[k] <= taps[k-1];
    end
  end
endmodule

// File: rtl/fir_seq.sv
module fir_seq #(
  parameter int TPB = 6,
  parameter int UPS = 4,
  localparam int SLOT = TPB + 2,
  localparam int SW = $clog2(SLOT),
  localparam int PW = (UPS > 1) ? $clog2(UPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start,
  output logic          busy,
  output logic [SW-1:0] slot,
  output logic          ch,
  output logic          rd_en,
  output logic          zshift,
  output logic          latch
);
  logic [PW-1:0] ph;
  logic          last_slot;

  assign last_slot = busy && run && (slot == SW'(SLOT-1));
  assign zshift    = last_slot && ch && (ph != PW'(UPS-1));
  assign rd_en     = busy && run && (slot < SW'(TPB));
  assign latch     = last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
      ch   <= 1'b0;
      ph   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      slot <= '0;
      ch   <= 1'b0;
      ph   <= '0;
    end else if (busy && run) begin
      if (slot == SW'(SLOT-1)) begin
        slot <= '0;
        if (ch) begin
          ch <= 1'b0;
          if (ph == PW'(UPS-1)) busy <= 1'b0;
          else ph <= ph + 1'b1;
        end else begin
          ch <= 1'b1;
        end
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(slot) && $stable(ch) && $stable(ph) && $stable(busy)));
endmodule

// File: rtl/fir_bank_acc.sv
module fir_bank_acc #(
  parameter int CW = 12,
  parameter int AW = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 rd_en,
  input  logic                 first,
  input  logic                 neg,
  input  logic signed [CW-1:0] coef,
  input  logic                 latch,
  output logic signed [AW-1:0] psum
);
  function automatic logic signed [AW-1:0] tap_term(input logic signed [CW-1:0] c,
                                                    input logic neg_in);
    logic signed [AW-1:0] ext;
    ext = {{(AW-CW){c[CW-1]}}, c};
    return neg_in ? -ext : ext;
  endfunction

  logic                 en_d, first_d, neg_d;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] term;

  assign term = tap_term(coef, neg_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d    <= 1'b0;
      first_d <= 1'b0;
      neg_d   <= 1'b0;
      acc     <= '0;
      psum    <= '0;
    end else if (run) begin
      en_d    <= rd_en;
      first_d <= first;
      neg_d   <= neg;
      if (en_d) acc <= first_d ? term : acc + term;
      if (latch) psum <= acc;
    end
  end
endmodule

// File: rtl/fir_iq_interp.sv
module fir_iq_interp
  import fir_iq_pkg::*;
#(
  parameter int CW    = 12,
  parameter int TPB   = 6,
  parameter int NBANK = 2,
  parameter int UPS   = 4,
  localparam int NTAP = TPB * NBANK,
  localparam int TW   = $clog2(NTAP),
  localparam int LW   = $clog2(TPB),
  localparam int RAW  = LW + 1,
  localparam int AW   = CW + $clog2(TPB),
  localparam int OW   = CW + $clog2(NTAP),
  localparam int SW   = $clog2(TPB + 2),
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_mode,
  input  logic                 prog_we,
  input  logic [TW-1:0]        prog_tap,
  input  logic signed [CW-1:0] prog_coef,
  input  logic                 chip_stb,
  input  logic                 chip_i,
  input  logic                 chip_q,
  input  logic                 chip_blank,
  output logic                 ready,
  output logic                 out_valid,
  output logic                 out_q,
  output logic signed [OW-1:0] out_data
);
  logic          run, busy, start, ch, rd_en, zshift, latch;
  logic [SW-1:0] slot;
  logic [LW-1:0] slot_c;
  logic          wr_ok;
  logic [BW-1:0] wr_bank;
  logic [LW-1:0] wr_loc;

  assign run   = !prog_mode;
  assign ready = run && !busy;
  assign start = ready && chip_stb;
  assign wr_ok = prog_mode && prog_we && !busy && (prog_tap < TW'(NTAP));

  always_comb begin
    wr_bank = BW'(prog_tap / TW'(TPB));
    wr_loc  = LW'(prog_tap % TW'(TPB));
    slot_c  = LW'(slot);
  end

  fir_seq #(.TPB(TPB), .UPS(UPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .start(start), .busy(busy),
    .slot(slot), .ch(ch), .rd_en(rd_en), .zshift(zshift), .latch(latch)
  );

  // Per-channel delay lines of stuffed samples
  samp_t [NTAP-1:0] line [2];
  logic [1:0]       chip_bits;
  assign chip_bits = {chip_q, chip_i};

  for (genvar c = 0; c < 2; c++) begin : g_chan
    samp_t din;
    always_comb begin
      din = '{zero: 1'b1, neg: 1'b0};
      if (start) din = '{zero: chip_blank, neg: !chip_bits[c]};
    end
    fir_delay_line #(.NTAP(NTAP)) u_line (
      .clk(clk), .rst_n(rst_n), .shift_en(start || zshift), .din(din), .taps(line[c])
    );
  end

  samp_t [NTAP-1:0]     line_sel;
  logic signed [AW-1:0] psum [NBANK];
  assign line_sel = ch ? line[1] : line[0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    samp_t                tap_s;
    logic [RAW-1:0]       ram_addr;
    logic signed [CW-1:0] rdata;

    always_comb begin
      tap_s = line_sel[b*TPB];
      for (int k = 0; k < TPB; k++)
        if (slot == SW'(k)) tap_s = line_sel[b*TPB + k];
      ram_addr = prog_mode ? {1'b0, wr_loc} : {tap_s.zero, slot_c};
    end

    fir_coef_ram #(.CW(CW), .RAW(RAW)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(wr_ok && (wr_bank == BW'(b))), .re(rd_en),
      .addr(ram_addr), .wdata(prog_coef), .rdata(rdata)
    );

    fir_bank_acc #(.CW(CW), .AW(AW)) u_acc (
      .clk(clk), .rst_n(rst_n), .run(run), .rd_en(rd_en), .first(slot == '0),
      .neg(tap_s.neg), .coef(rdata), .latch(latch), .psum(psum[b])
    );
  end

  function automatic logic signed [OW-1:0] add_partials(input logic signed [AW-1:0] p [NBANK]);
    logic signed [OW-1:0] tot;
    tot = '0;
    for (int b = 0; b < NBANK; b++) tot = tot + {{(OW-AW){p[b][AW-1]}}, p[b]};
    return tot;
  endfunction

  logic psum_v, psum_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psum_v    <= 1'b0;
      psum_ch   <= 1'b0;
      out_valid <= 1'b0;
      out_q     <= 1'b0;
      out_data  <= '0;
    end else if (run) begin
      psum_v    <= latch;
      if (latch) psum_ch <= ch;
      out_valid <= psum_v;
      if (psum_v) begin
        out_data <= add_partials(psum);
        out_q    <= psum_ch;
      end
    end else begin
      out_valid <= 1'b0;
    end
  end

  // Checker state: channel of the previous output strobe
  logic last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else if (out_valid) last_q <= out_q;
  end

  localparam int BOUND = NTAP * (1 << (CW - 1));

  assert_out_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_iq_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_q != last_q));
  assert_quiet_in_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |=> !out_valid);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($signed(out_data) <= BOUND) && ($signed(out_data) >= -BOUND)));
endmodule

// File: tb/fir_iq_interp_test.sv
module fir_iq_interp_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, prog_mode, prog_we, chip_stb, chip_i, chip_q, chip_blank;
  logic [3:0]  prog_tap;
  logic signed [11:0] prog_coef;
  logic        ready, out_valid, out_q;
  logic signed [15:0] out_data;

  fir_iq_interp uut (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .prog_we(prog_we),
    .prog_tap(prog_tap), .prog_coef(prog_coef), .chip_stb(chip_stb),
    .chip_i(chip_i), .chip_q(chip_q), .chip_blank(chip_blank),
    .ready(ready), .out_valid(out_valid), .out_q(out_q), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0, fails = 0;
  int    coef [12];
  int    hi [3], hq [3];
  int    exp_v [$];
  bit    exp_c [$];
  string tag = "R3";
  bit    finished = 0;
  int    e_val;
  bit    e_ch;

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int chip_val(bit c, bit bl);
    if (bl) return 0;
    return c ? 1 : -1;
  endfunction

  function automatic int poly(int p, int c0, int c1, int c2);
    return coef[p] * c0 + coef[p+4] * c1 + coef[p+8] * c2;
  endfunction

  // Output monitor compares against the expected queue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_v.size() == 0) begin
        check(0, "R2 extra output", 1, 0);
      end else begin
        e_val = exp_v.pop_front();
        e_ch  = exp_c.pop_front();
        check(out_q == e_ch, "R2 channel order", int'(out_q), int'(e_ch));
        check(int'(out_data) == e_val, tag, int'(out_data), e_val);
      end
    end
  end

  task automatic prog_write(int tap, int val, bit takes);
    @(negedge clk);
    prog_we = 1; prog_tap = tap[3:0]; prog_coef = val[11:0];
    @(negedge clk);
    prog_we = 0;
    if (takes) coef[tap] = val;
  endtask

  task automatic send_chip(bit ci, bit cq, bit bl);
    while (!ready) @(negedge clk);
    chip_stb = 1; chip_i = ci; chip_q = cq; chip_blank = bl;
    hi[2] = hi[1]; hi[1] = hi[0]; hi[0] = chip_val(ci, bl);
    hq[2] = hq[1]; hq[1] = hq[0]; hq[0] = chip_val(cq, bl);
    for (int p = 0; p < 4; p++) begin
      exp_v.push_back(poly(p, hi[0], hi[1], hi[2])); exp_c.push_back(1'b0);
      exp_v.push_back(poly(p, hq[0], hq[1], hq[2])); exp_c.push_back(1'b1);
    end
    @(negedge clk);
    chip_stb = 0;
  endtask

  task automatic wait_idle();
    while (!ready || exp_v.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", exp_v.size(), 0);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    for (int k = 0; k < 12; k++) coef[k] = 0;
    for (int k = 0; k < 3; k++) begin hi[k] = 0; hq[k] = 0; end
    rst_n = 0; prog_mode = 0; prog_we = 0; prog_tap = 0; prog_coef = 0;
    chip_stb = 0; chip_i = 0; chip_q = 0; chip_blank = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    check(out_data == 0, "R1 out_data", int'(out_data), 0);
    check(ready == 1, "R1 ready", int'(ready), 1);

    // R1: zero coefficients give zero outputs
    tag = "R1";
    send_chip(1, 0, 0);
    wait_idle();

    // R5: program taps, out-of-range index ignored
    prog_mode = 1;
    @(negedge clk);
    check(ready == 0, "R8 ready in program mode", int'(ready), 0);
    for (int k = 0; k < 12; k++) prog_write(k, int'($urandom % 4096) - 2048, 1);
    prog_write(13, 555, 0);
    prog_mode = 0;
    @(negedge clk);

    // R2: latency and spacing
    tag = "R5";
    send_chip(1, 0, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!out_valid && n < 50);
    check(n == 9, "R2 first output latency", n, 9);
    n = 0;
    do begin @(negedge clk); n++; end while (!out_valid && n < 50);
    check(n == 8, "R2 output spacing", n, 8);
    wait_idle();

    // R6: write without program mode ignored
    prog_write(2, 777, 0);
    tag = "R6";
    send_chip(0, 1, 0);
    send_chip(1, 1, 0);
    wait_idle();

    // R3: random chips with occasional blanks
    tag = "R3";
    for (int j = 0; j < 30; j++)
      send_chip($urandom % 2, $urandom % 2, ($urandom % 8) == 0);
    wait_idle();

    // R8: strobe while busy ignored
    tag = "R8";
    send_chip(1, 0, 0);
    repeat (5) @(negedge clk);
    check(ready == 0, "R8 ready while busy", int'(ready), 0);
    chip_stb = 1; chip_i = 0; chip_q = 1; chip_blank = 0;
    @(negedge clk);
    chip_stb = 0;
    send_chip(0, 0, 0);
    wait_idle();

    // R7: pause mid-slot, write attempt during pause is ignored (R6)
    tag = "R7";
    send_chip(1, 1, 0);
    repeat (20) @(negedge clk);
    prog_mode = 1;
    prog_write(0, 1000, 0);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      check(out_valid == 0, "R7 no output while paused", int'(out_valid), 0);
    end
    check(ready == 0, "R7 ready while paused", int'(ready), 0);
    prog_mode = 0;
    send_chip(0, 1, 0);
    wait_idle();

    // R4: blank chips contribute zero
    tag = "R4";
    send_chip(1, 1, 1);
    send_chip(0, 1, 0);
    send_chip(1, 0, 1);
    send_chip(1, 1, 1);
    send_chip(0, 0, 1);
    wait_idle();

    // R9: extreme coefficients reach +-6144
    prog_mode = 1;
    for (int k = 0; k < 12; k++) prog_write(k, -2048, 1);
    prog_mode = 0;
    @(negedge clk);
    tag = "R9";
    for (int j = 0; j < 3; j++) send_chip(1, 1, 0);
    check(exp_v[exp_v.size()-1] == -6144, "R9 model extreme", exp_v[exp_v.size()-1], -6144);
    for (int j = 0; j < 3; j++) send_chip(0, 0, 0);
    wait_idle();
    check(int'(out_data) == 6144, "R9 positive extreme", int'(out_data), 6144);

    check(exp_v.size() == 0, "R2 all outputs delivered", exp_v.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule